// File: doc/BRIEF.md
# Scalar/Vector Writeback Stage with Redirect

This block is the last stage of a small processor pipeline that handles both scalar and vector instructions. It accepts one retiring instruction descriptor per cycle. Each descriptor carries an opcode class, a format, a destination tag, two scalar operands, two vector operands, an auxiliary field and a target address. The stage turns the descriptor into register-file writes or into a change of program flow.

The stage keeps a small queue of pending destination tags. The issue side pushes a tag into it whenever it reserves a register, and every register write at retirement pops one tag. A POP instruction pops two tags and writes two scalar registers in the same cycle. A vector write combines two operands lane by lane: the result vector fills the lanes below a length held in the auxiliary field, and the second vector operand fills the rest. A control-transfer instruction that has no destination and a positive target loads the program counter, squashes the upstream stage and empties the tag queue. A JAL that redirects also writes a link value into scalar register 1.

Every result is registered and appears on the outputs exactly one clock after the descriptor is sampled.

Top module: `wb_commit`

## Requirements
- R1: After reset, every write enable, `pc_load`, `squash` and `err_empty` is low, and the tag queue is empty.
- R2: A valid descriptor with `in_op` = 0 (NOP) produces no write, no redirect and no squash, and it leaves the tag queue unchanged.
- R3: A valid non-NOP descriptor with `in_dst` != 0 and `in_fmt` = 0 (scalar) raises `sb_we` one cycle later, with `sb_addr` = `in_dst` and `sb_data` = `in_s1`. It pops one tag.
- R4: With `in_fmt` = 1 (scalar-vector) or 2 (vector-vector) and `in_dst` != 0, `vw_we` rises one cycle later with `vw_addr` = `in_dst`. In `vw_data`, lane i (bits i*32 and up) takes lane i of `in_v1` when i < `in_aux`, and lane i of `in_v3` otherwise.
- R5: With `in_fmt` = 2 and `in_aux` = 0, every lane of `vw_data` is zero.
- R6: POP (`in_op` = 10) with a destination and scalar format writes in the same cycle on two ports. Port A gets `sa_addr` = the tag at the queue head and `sa_data` = `in_s3`. Port B gets `sb_addr` = `in_dst` and `sb_data` = `in_s1`. Two tags are popped.
- R7: A descriptor with `in_dst` != 0 never redirects, even when its opcode is a control transfer.
- R8: A redirect happens when `in_dst` = 0, the opcode is a control transfer (codes 2 to 11) and `in_target` is greater than zero as a signed value. One cycle later, `pc_load` and `squash` are high for one cycle and `pc_value` = `in_target`.
- R9: A target of zero or a negative target, or a descriptor with no destination and a non-control opcode (1, 12 to 15), retires with no write and no redirect.
- R10: A redirecting JAL (`in_op` = 4) also raises `sa_we` with `sa_addr` = 1 and `sa_data` = `in_aux` + 1. A JAL that does not redirect writes no link value.
- R11: A redirect empties the tag queue, so a later write finds the queue empty.
- R12: A write that needs more tags than the queue holds sets `err_empty`. The flag stays high until reset, whatever comes after.
- R13: Tags pop in the order they were pushed, and a push into a full queue (8 entries) is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tag_push | input | 1 | Push `tag_in` into the pending-tag queue |
| tag_in | input | 5 | Tag to push |
| in_valid | input | 1 | Descriptor valid this cycle |
| in_op | input | 4 | Opcode class: 0 NOP, 1 plain, 2 JMP, 3 JRL, 4 JAL, 5 BEQ, 6 BGT, 7 BUF, 8 BOF, 9 PUSH, 10 POP, 11 RET, 12-15 plain |
| in_fmt | input | 2 | Format: 0 scalar, 1 scalar-vector, 2 vector-vector, 3 scalar |
| in_dst | input | 5 | Destination tag, 0 means no destination |
| in_s1 | input | 32 | First scalar operand |
| in_s3 | input | 32 | Third scalar operand |
| in_v1 | input | 256 | Result vector, 8 lanes |
| in_v3 | input | 256 | Third vector operand, 8 lanes |
| in_aux | input | 32 | Auxiliary field: vector length and link base |
| in_target | input | 32 | Redirect target, signed |
| sa_we | output | 1 | Scalar port A write enable |
| sa_addr | output | 5 | Scalar port A address |
| sa_data | output | 32 | Scalar port A data |
| sb_we | output | 1 | Scalar port B write enable |
| sb_addr | output | 5 | Scalar port B address |
| sb_data | output | 32 | Scalar port B data |
| vw_we | output | 1 | Vector write enable |
| vw_addr | output | 5 | Vector write address |
| vw_data | output | 256 | Merged vector data |
| pc_load | output | 1 | Program-counter load strobe |
| pc_value | output | 32 | New program counter |
| squash | output | 1 | Squash to the preceding stage |
| err_empty | output | 1 | Sticky error: a write found the tag queue empty |

## Verification
Writes, redirect strobes and the error flag are all due on the first clock edge after the descriptor is sampled. The bench drives each descriptor on a falling edge, removes it on the next falling edge, and compares the outputs at that moment, which falls between the edge that registered them and the edge that clears them. Queue state cannot be seen directly, so it is checked through its effects one descriptor later: the head tag that a POP shows on port A, and whether a later write raises the error flag.

// File: rtl/wb_commit.sv
module wb_commit #(
  parameter int LANES    = 8,
  parameter int DW       = 32,
  parameter int AW       = 32,
  parameter int TAGW     = 5,
  parameter int QDEPTH   = 8,
  parameter int LINK_REG = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tag_push,
  input  logic [TAGW-1:0]       tag_in,
  input  logic                  in_valid,
  input  logic [3:0]            in_op,
  input  logic [1:0]            in_fmt,
  input  logic [TAGW-1:0]       in_dst,
  input  logic [DW-1:0]         in_s1,
  input  logic [DW-1:0]         in_s3,
  input  logic [LANES*DW-1:0]   in_v1,
  input  logic [LANES*DW-1:0]   in_v3,
  input  logic [DW-1:0]         in_aux,
  input  logic [AW-1:0]         in_target,
  output logic                  sa_we,
  output logic [TAGW-1:0]       sa_addr,
  output logic [DW-1:0]         sa_data,
  output logic                  sb_we,
  output logic [TAGW-1:0]       sb_addr,
  output logic [DW-1:0]         sb_data,
  output logic                  vw_we,
  output logic [TAGW-1:0]       vw_addr,
  output logic [LANES*DW-1:0]   vw_data,
  output logic                  pc_load,
  output logic [AW-1:0]         pc_value,
  output logic                  squash,
  output logic                  err_empty
);
  localparam int VW = LANES * DW;
  localparam int PW = $clog2(QDEPTH);
  localparam int CW = PW + 1;
  localparam logic [3:0] OP_NOP = 4'd0;
  localparam logic [3:0] OP_JAL = 4'd4;
  localparam logic [3:0] OP_POP = 4'd10;
  localparam logic [3:0] OP_CTL_LO = 4'd2;
  localparam logic [3:0] OP_CTL_HI = 4'd11;
  localparam logic [1:0] FMT_SV = 2'd1;
  localparam logic [1:0] FMT_VV = 2'd2;

  logic [TAGW-1:0] tags [QDEPTH];
  logic [PW-1:0]   rd_ptr, wr_ptr;
  logic [CW-1:0]   count;

  logic          fire, do_write, do_redir, is_pop, is_vec, is_ctl;
  logic [CW-1:0] need, got, left;
  logic          short_q, push_ok;
  logic [VW-1:0] merged;

  assign fire     = in_valid && (in_op != OP_NOP);
  assign is_pop   = (in_op == OP_POP);
  assign is_ctl   = (in_op >= OP_CTL_LO) && (in_op <= OP_CTL_HI);
  assign is_vec   = (in_fmt == FMT_SV) || (in_fmt == FMT_VV);
  assign do_write = fire && (in_dst != '0);
  assign do_redir = fire && (in_dst == '0) && is_ctl &&
                    !in_target[AW-1] && (in_target != '0);

  assign need    = !do_write ? CW'(0) : (is_pop ? CW'(2) : CW'(1));
  assign short_q = need > count;
  assign got     = short_q ? count : need;
  assign left    = count - got;
  assign push_ok = tag_push && (left < CW'(QDEPTH));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[g*DW +: DW] =
      ((in_fmt == FMT_VV) && (in_aux == '0)) ? '0 :
      (DW'(g) < in_aux) ? in_v1[g*DW +: DW] : in_v3[g*DW +: DW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sa_we <= 1'b0; sa_addr <= '0; sa_data <= '0;
      sb_we <= 1'b0; sb_addr <= '0; sb_data <= '0;
      vw_we <= 1'b0; vw_addr <= '0; vw_data <= '0;
      pc_load <= 1'b0; pc_value <= '0; squash <= 1'b0;
      err_empty <= 1'b0;
    end else begin
      sa_we   <= 1'b0;
      sb_we   <= 1'b0;
      vw_we   <= 1'b0;
      pc_load <= 1'b0;
      squash  <= 1'b0;
      if (short_q) err_empty <= 1'b1;
      if (do_write) begin
        if (is_pop && (count != '0)) begin
          sa_we   <= 1'b1;
          sa_addr <= tags[rd_ptr];
          sa_data <= in_s3;
        end
        if (is_vec) begin
          vw_we   <= 1'b1;
          vw_addr <= in_dst;
          vw_data <= merged;
        end else begin
          sb_we   <= 1'b1;
          sb_addr <= in_dst;
          sb_data <= in_s1;
        end
      end
      if (do_redir) begin
        pc_load  <= 1'b1;
        pc_value <= in_target;
        squash   <= 1'b1;
        if (in_op == OP_JAL) begin
          sa_we   <= 1'b1;
          sa_addr <= TAGW'(LINK_REG);
          sa_data <= in_aux + DW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else if (do_redir) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      rd_ptr <= rd_ptr + got[PW-1:0];
      if (push_ok) wr_ptr <= wr_ptr + PW'(1);
      count <= left + CW'(push_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !do_redir) tags[wr_ptr] <= tag_in;
  end
endmodule

// File: rtl/wb_commit_chk.sv
module wb_commit_chk #(
  parameter int AW   = 32,
  parameter int TAGW = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [3:0]      in_op,
  input logic [1:0]      in_fmt,
  input logic [TAGW-1:0] in_dst,
  input logic [AW-1:0]   in_target,
  input logic            sa_we,
  input logic            sb_we,
  input logic            vw_we,
  input logic            pc_load,
  input logic [AW-1:0]   pc_value,
  input logic            squash,
  input logic            err_empty
);
  assert_nop_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 4'd0) |=> (!sa_we && !sb_we && !vw_we && !pc_load && !squash));

  assert_pop_two_ports_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 4'd10 && in_dst != '0 && in_fmt == 2'd0) |=> sb_we);

  assert_dst_blocks_redirect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_dst != '0) |=> !pc_load);

  assert_target_positive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> (!pc_value[AW-1] && pc_value != '0));

  assert_squash_follows_pc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> squash);

  assert_nonpositive_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_target[AW-1] || in_target == '0)) |=> (!pc_load && !squash));

  assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    err_empty |=> err_empty);
endmodule

bind wb_commit wb_commit_chk #(.AW(AW), .TAGW(TAGW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_fmt(in_fmt),
  .in_dst(in_dst), .in_target(in_target), .sa_we(sa_we), .sb_we(sb_we),
  .vw_we(vw_we), .pc_load(pc_load), .pc_value(pc_value), .squash(squash),
  .err_empty(err_empty)
);

// File: tb/test_wb_commit.sv
`timescale 1ns/1ps
module test_wb_commit;
  localparam int VW = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tag_push = 1'b0;
  logic [4:0] tag_in = '0;
  logic in_valid = 1'b0;
  logic [3:0] in_op = '0;
  logic [1:0] in_fmt = '0;
  logic [4:0] in_dst = '0;
  logic [31:0] in_s1 = '0, in_s3 = '0, in_aux = '0, in_target = '0;
  logic [VW-1:0] in_v1, in_v3;
  logic sa_we, sb_we, vw_we, pc_load, squash, err_empty;
  logic [4:0] sa_addr, sb_addr, vw_addr;
  logic [31:0] sa_data, sb_data, pc_value;
  logic [VW-1:0] vw_data;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wb_commit i_wb_commit (
    .clk(clk), .rst_n(rst_n), .tag_push(tag_push), .tag_in(tag_in),
    .in_valid(in_valid), .in_op(in_op), .in_fmt(in_fmt), .in_dst(in_dst),
    .in_s1(in_s1), .in_s3(in_s3), .in_v1(in_v1), .in_v3(in_v3),
    .in_aux(in_aux), .in_target(in_target),
    .sa_we(sa_we), .sa_addr(sa_addr), .sa_data(sa_data),
    .sb_we(sb_we), .sb_addr(sb_addr), .sb_data(sb_data),
    .vw_we(vw_we), .vw_addr(vw_addr), .vw_data(vw_data),
    .pc_load(pc_load), .pc_value(pc_value), .squash(squash),
    .err_empty(err_empty)
  );

  typedef struct packed {
    logic [23:0] req;
    logic [3:0]  op;
    logic [1:0]  fmt;
    logic [4:0]  dst;
    logic [31:0] s1;
    logic [31:0] s3;
    logic [31:0] aux;
    logic [31:0] tgt;
    logic [1:0]  pushn;
    logic        ew0;
    logic [4:0]  ew0a;
    logic [31:0] ew0d;
    logic        ew1;
    logic        ev;
    logic        epc;
  } row_t;

  localparam int NROWS = 17;
  localparam row_t ROWS [NROWS] = '{
    '{"R2 ", 4'd0,  2'd0, 5'd5, 32'h11,   32'h0,  32'h0,  32'h0,        2'd0, 1'b0, 5'd0,  32'h0,  1'b0, 1'b0, 1'b0},
    '{"R3 ", 4'd1,  2'd0, 5'd5, 32'h1234, 32'h0,  32'h0,  32'h0,        2'd1, 1'b0, 5'd0,  32'h0,  1'b1, 1'b0, 1'b0},
    '{"R4 ", 4'd1,  2'd1, 5'd6, 32'h0,    32'h0,  32'd3,  32'h0,        2'd1, 1'b0, 5'd0,  32'h0,  1'b0, 1'b1, 1'b0},
    '{"R4 ", 4'd12, 2'd2, 5'd7, 32'h0,    32'h0,  32'd5,  32'h0,        2'd1, 1'b0, 5'd0,  32'h0,  1'b0, 1'b1, 1'b0},
    '{"R5 ", 4'd1,  2'd2, 5'd7, 32'h0,    32'h0,  32'd0,  32'h0,        2'd1, 1'b0, 5'd0,  32'h0,  1'b0, 1'b1, 1'b0},
    '{"R4 ", 4'd1,  2'd1, 5'd6, 32'h0,    32'h0,  32'd0,  32'h0,        2'd1, 1'b0, 5'd0,  32'h0,  1'b0, 1'b1, 1'b0},
    '{"R4 ", 4'd1,  2'd2, 5'd3, 32'h0,    32'h0,  32'd9,  32'h0,        2'd1, 1'b0, 5'd0,  32'h0,  1'b0, 1'b1, 1'b0},
    '{"R6 ", 4'd10, 2'd0, 5'd4, 32'hAA,   32'hBB, 32'h0,  32'h0,        2'd2, 1'b1, 5'd20, 32'hBB, 1'b1, 1'b0, 1'b0},
    '{"R8 ", 4'd2,  2'd0, 5'd0, 32'h0,    32'h0,  32'h0,  32'h40,       2'd0, 1'b0, 5'd0,  32'h0,  1'b0, 1'b0, 1'b1},
    '{"R10", 4'd4,  2'd0, 5'd0, 32'h0,    32'h0,  32'h10, 32'h80,       2'd0, 1'b1, 5'd1,  32'h11, 1'b0, 1'b0, 1'b1},
    '{"R7 ", 4'd5,  2'd0, 5'd9, 32'h77,   32'h0,  32'h0,  32'h50,       2'd1, 1'b0, 5'd0,  32'h0,  1'b1, 1'b0, 1'b0},
    '{"R9 ", 4'd6,  2'd0, 5'd0, 32'h0,    32'h0,  32'h0,  32'h0,        2'd0, 1'b0, 5'd0,  32'h0,  1'b0, 1'b0, 1'b0},
    '{"R9 ", 4'd11, 2'd0, 5'd0, 32'h0,    32'h0,  32'h0,  32'hFFFFFFFC, 2'd0, 1'b0, 5'd0,  32'h0,  1'b0, 1'b0, 1'b0},
    '{"R9 ", 4'd1,  2'd0, 5'd0, 32'h0,    32'h0,  32'h0,  32'h60,       2'd0, 1'b0, 5'd0,  32'h0,  1'b0, 1'b0, 1'b0},
    '{"R8 ", 4'd11, 2'd0, 5'd0, 32'h0,    32'h0,  32'h0,  32'h1,        2'd0, 1'b0, 5'd0,  32'h0,  1'b0, 1'b0, 1'b1},
    '{"R2 ", 4'd0,  2'd0, 5'd0, 32'h0,    32'h0,  32'h0,  32'h40,       2'd0, 1'b0, 5'd0,  32'h0,  1'b0, 1'b0, 1'b0},
    '{"R10", 4'd4,  2'd0, 5'd0, 32'h0,    32'h0,  32'h10, 32'h0,        2'd0, 1'b0, 5'd0,  32'h0,  1'b0, 1'b0, 1'b0}
  };

  function automatic logic [31:0] v1_lane(int i);
    return 32'h100 + 32'(i);
  endfunction
  function automatic logic [31:0] v3_lane(int i);
    return 32'hFFFFFFFF - 32'(i);
  endfunction
  function automatic logic [VW-1:0] vref(logic [1:0] fmt, logic [31:0] aux);
    logic [VW-1:0] r;
    for (int i = 0; i < 8; i++) begin
      if (fmt == 2'd2 && aux == 0) r[i*32 +: 32] = '0;
      else if (32'(i) < aux) r[i*32 +: 32] = v1_lane(i);
      else r[i*32 +: 32] = v3_lane(i);
    end
    return r;
  endfunction

  initial begin
    for (int i = 0; i < 8; i++) begin
      in_v1[i*32 +: 32] = v1_lane(i);
      in_v3[i*32 +: 32] = v3_lane(i);
    end
  end

  task automatic chk(input string what, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic push(input logic [4:0] t);
    @(negedge clk);
    tag_push = 1'b1;
    tag_in = t;
    @(negedge clk);
    tag_push = 1'b0;
  endtask

  task automatic issue(input logic [3:0] op, input logic [1:0] fmt, input logic [4:0] dst,
                       input logic [31:0] s1, input logic [31:0] s3,
                       input logic [31:0] aux, input logic [31:0] tgt);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_fmt = fmt; in_dst = dst;
    in_s1 = s1; in_s3 = s3; in_aux = aux; in_target = tgt;
    @(negedge clk);
    in_valid = 1'b0; in_op = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      vectors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk("R1 sa_we", VW'(sa_we), '0);
    chk("R1 sb_we", VW'(sb_we), '0);
    chk("R1 vw_we", VW'(vw_we), '0);
    chk("R1 pc_load", VW'(pc_load), '0);
    chk("R1 squash", VW'(squash), '0);
    chk("R1 err_empty", VW'(err_empty), '0);

    for (int r = 0; r < NROWS; r++) begin
      row_t w = ROWS[r];
      string tg = $sformatf("%s row %0d", w.req, r);
      for (int p = 0; p < int'(w.pushn); p++) push(5'(20 + p));
      issue(w.op, w.fmt, w.dst, w.s1, w.s3, w.aux, w.tgt);
      chk({tg, " sa_we"}, VW'(sa_we), VW'(w.ew0));
      if (w.ew0) begin
        chk({tg, " sa_addr"}, VW'(sa_addr), VW'(w.ew0a));
        chk({tg, " sa_data"}, VW'(sa_data), VW'(w.ew0d));
      end
      chk({tg, " sb_we"}, VW'(sb_we), VW'(w.ew1));
      if (w.ew1) begin
        chk({tg, " sb_addr"}, VW'(sb_addr), VW'(w.dst));
        chk({tg, " sb_data"}, VW'(sb_data), VW'(w.s1));
      end
      chk({tg, " vw_we"}, VW'(vw_we), VW'(w.ev));
      if (w.ev) begin
        chk({tg, " vw_addr"}, VW'(vw_addr), VW'(w.dst));
        chk({tg, " vw_data"}, vw_data, vref(w.fmt, w.aux));
      end
      chk({tg, " pc_load"}, VW'(pc_load), VW'(w.epc));
      chk({tg, " squash"}, VW'(squash), VW'(w.epc));
      if (w.epc) chk({tg, " pc_value"}, VW'(pc_value), VW'(w.tgt));
      chk({tg, " R12 err_empty clear"}, VW'(err_empty), '0);
    end

    // R11: redirect flushes the queue, next write finds it empty
    do_reset();
    push(5'd30);
    push(5'd31);
    issue(4'd2, 2'd0, 5'd0, 32'h0, 32'h0, 32'h0, 32'h5);
    chk("R11 redirect pc_load", VW'(pc_load), VW'(1'b1));
    chk("R11 err before write", VW'(err_empty), '0);
    issue(4'd1, 2'd0, 5'd2, 32'h9, 32'h0, 32'h0, 32'h0);
    chk("R11 err after flushed write", VW'(err_empty), VW'(1'b1));
    chk("R11 write still lands", VW'(sb_we), VW'(1'b1));
    // R12: sticky through idle and a good write
    issue(4'd0, 2'd0, 5'd0, 32'h0, 32'h0, 32'h0, 32'h0);
    repeat (3) @(negedge clk);
    chk("R12 err sticky idle", VW'(err_empty), VW'(1'b1));
    push(5'd12);
    issue(4'd1, 2'd0, 5'd3, 32'h5, 32'h0, 32'h0, 32'h0);
    chk("R12 err sticky after good write", VW'(err_empty), VW'(1'b1));
    do_reset();
    @(negedge clk);
    chk("R1 err cleared by reset", VW'(err_empty), '0);

    // R13: ordering and drop on full
    for (int t = 1; t <= 9; t++) push(5'(t));
    for (int k = 0; k < 4; k++) begin
      issue(4'd10, 2'd0, 5'd2, 32'h1, 32'h2, 32'h0, 32'h0);
      chk($sformatf("R13 pop %0d head", k), VW'(sa_addr), VW'(5'(1 + 2 * k)));
      chk($sformatf("R13 pop %0d sa_we", k), VW'(sa_we), VW'(1'b1));
    end
    chk("R13 err after 8 pops", VW'(err_empty), '0);
    issue(4'd1, 2'd0, 5'd2, 32'h1, 32'h0, 32'h0, 32'h0);
    chk("R13 ninth push dropped", VW'(err_empty), VW'(1'b1));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule